// File: doc/BRIEF.md
# Timer Interrupt Router

This block takes the one-cycle fire events of a bank of timer channels and turns them into interrupt activity. Each channel either drives one line of an interrupt line vector, in level or pulse form, or, when its message mode is on, posts a 32-bit memory write through a valid/ready port instead of touching any line. The block keeps the per-channel interrupt status bits. Software clears a bit by writing a one to it.

A legacy override mode fixes the targets of channels 0 and 1 to lines 0 and 8. In this mode the two external legacy interrupt inputs (periodic-timer and real-time-clock) are cut off from those lines, and an enable output for the external periodic timer is driven low. Lines at or above a parameterised index are active-low. The comparators that produce the fire events sit outside this block.

Top module: `irq_route_hub`

## Requirements
- R1: After reset `sts_o` is all zero, `pit_en_o` is 1 and `msg_valid_o` is 0. With both legacy inputs low, every line below 16 is low and every line from 16 up is high.
- R2: A fire on an active level-mode channel with message mode off sets its status bit at that clock edge. It also asserts the line selected by its 5-bit route field, and the line stays asserted until the bit is cleared.
- R3: A fire on an active pulse-mode channel with message mode off clears its status bit and asserts its routed line for exactly one cycle.
- R4: When `sts_wr_i` is high, every status bit whose `sts_wdata_i` bit is 1 clears at that edge and its line deasserts. Bits written with 0 keep their value.
- R5: Lines with index 16 or higher are active-low: asserted means 0, idle means 1.
- R6: A channel is active only when both its `ch_en_i` bit and `glob_en_i` are 1. While a channel is inactive, its status bit and its queued message are cleared and fires are ignored.
- R7: A fire on an active channel in message mode drives no line and leaves its status bit unchanged. It queues one write, and the write is offered on `msg_*` from the second edge after the fire onward. Bits 63:32 of the channel's `ch_msg_word_i` slice give the address and bits 31:0 give the data. Address and data hold steady while `msg_valid_o` is high and `msg_ready_i` is low.
- R8: The edge at which a channel's message-mode bit goes from 0 to 1 clears that channel's status bit.
- R9: While `legacy_i` is 1, channel 0 drives line 0 and channel 1 drives line 8, whatever their route fields hold.
- R10: While `legacy_i` is 1, `pit_irq_i` and the RTC level do not reach lines 0 and 8. `pit_en_o` is 0 from the edge after `legacy_i` rises.
- R11: The RTC input level is registered every cycle, also during legacy mode. After `legacy_i` falls, `pit_en_o` returns to 1 at the next edge and line 8 shows the last registered RTC level.
- R12: Outside legacy mode, line 0 ORs in `pit_irq_i` directly and line 8 ORs in the RTC level registered at the previous edge.
- R13: Queued writes leave one per accepted handshake, lowest channel number first. A channel that fires again while its write is still queued is coalesced into the one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fire_i | input | N_CH | Per-channel fire pulse |
| glob_en_i | input | 1 | Global interrupt enable |
| legacy_i | input | 1 | Legacy override mode |
| ch_en_i | input | N_CH | Per-channel enable |
| ch_level_i | input | N_CH | 1 = level mode, 0 = pulse mode |
| ch_msg_en_i | input | N_CH | Per-channel message mode |
| ch_route_i | input | N_CH*ROUTE_W | Route fields, channel c at bits c*ROUTE_W upward |
| ch_msg_word_i | input | N_CH*64 | Message words, channel c at bits c*64 upward |
| sts_wr_i | input | 1 | Status write strobe |
| sts_wdata_i | input | N_CH | Status write data, ones clear |
| pit_irq_i | input | 1 | External periodic-timer interrupt |
| rtc_irq_i | input | 1 | External real-time-clock interrupt level |
| irq_o | output | N_LINES | Interrupt lines |
| sts_o | output | N_CH | Interrupt status bits |
| pit_en_o | output | 1 | Enable for the external periodic timer |
| msg_valid_o | output | 1 | Message write valid |
| msg_ready_i | input | 1 | Message write accepted |
| msg_addr_o | output | 32 | Message write address |
| msg_data_o | output | 32 | Message write data |

## Verification
The hardest situations to reach are those where several clearing causes meet one channel in the same cycle. Examples are a message-mode rise on a channel whose status is set, or a fire in the same cycle as a one-to-clear write. Another is a second message fire arriving while the write port is stalled. Directed sequences set these up on purpose: a pending level interrupt before switching a channel to message mode, and two simultaneous message fires with `msg_ready_i` held low. A long seeded random phase then mixes enables, modes, legacy toggles and backpressure, and a cycle model in the bench checks every output after each edge.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
   localparam int MSG_W      = 32;
   localparam int WORD_W     = 2 * MSG_W;
   localparam int LEG_LINE_A = 0;
   localparam int LEG_LINE_B = 8;
   typedef logic [MSG_W-1:0] msg_half_t;
endpackage

// File: rtl/irq_chan_state.sv
module irq_chan_state (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic act,
   input  logic level,
   input  logic msg_en,
   input  logic clr_req,
   output logic sts,
   output logic pulse,
   output logic msg_fire
);
   logic msg_en_q;
   logic pin_fire;

   assign pin_fire = act & fire & ~msg_en;
   assign msg_fire = act & fire & msg_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sts      <= 1'b0;
         pulse    <= 1'b0;
         msg_en_q <= 1'b0;
      end else begin
         msg_en_q <= msg_en;
         pulse    <= pin_fire & ~level;
         if (!act)
            sts <= 1'b0;
         else if (msg_en & ~msg_en_q)
            sts <= 1'b0;
         else if (pin_fire)
            sts <= level;
         else if (clr_req)
            sts <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_line_map.sv
module irq_line_map #(
   parameter int N_CH     = 8,
   parameter int N_LINES  = 24,
   parameter int ROUTE_W  = 5,
   parameter int INV_FROM = 16
) (
   input  logic [N_CH-1:0]         sts,
   input  logic [N_CH-1:0]         pulse,
   input  logic [N_CH*ROUTE_W-1:0] route,
   input  logic                    legacy,
   input  logic                    pit_in,
   input  logic                    rtc_lvl,
   output logic [N_LINES-1:0]      irq
);
   import irq_route_pkg::*;

   int            eff [N_CH];
   logic [N_LINES-1:0] act;

   always_comb begin
      for (int c = 0; c < N_CH; c++) begin
         eff[c] = int'(route[c*ROUTE_W +: ROUTE_W]);
         if (legacy && c == 0) eff[c] = LEG_LINE_A;
         if (legacy && c == 1) eff[c] = LEG_LINE_B;
      end
      for (int l = 0; l < N_LINES; l++) begin
         act[l] = 1'b0;
         for (int c = 0; c < N_CH; c++)
            if (eff[c] == l) act[l] = act[l] | sts[c] | pulse[c];
      end
      if (!legacy) begin
         act[LEG_LINE_A] = act[LEG_LINE_A] | pit_in;
         act[LEG_LINE_B] = act[LEG_LINE_B] | rtc_lvl;
      end
   end

   for (genvar l = 0; l < N_LINES; l++) begin : g_pol
      if (l >= INV_FROM) begin : g_low
         assign irq[l] = ~act[l];
      end else begin : g_high
         assign irq[l] = act[l];
      end
   end
endmodule

// File: rtl/irq_msg_arb.sv
module irq_msg_arb #(
   parameter int N_CH = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_CH-1:0]        act,
   input  logic [N_CH-1:0]        msg_fire,
   input  logic [N_CH*64-1:0]     words,
   input  logic                   ready,
   output logic                   valid,
   output irq_route_pkg::msg_half_t addr,
   output irq_route_pkg::msg_half_t data
);
   import irq_route_pkg::*;
   localparam int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1;

   logic [N_CH-1:0]  pend;
   logic [N_CH-1:0]  launch;
   logic [IDX_W-1:0] sel;
   logic             hit;
   logic             load;

   always_comb begin
      hit = 1'b0;
      sel = '0;
      for (int c = N_CH - 1; c >= 0; c--)
         if (pend[c]) begin
            hit = 1'b1;
            sel = IDX_W'(c);
         end
      load = hit & (~valid | ready);
      for (int c = 0; c < N_CH; c++)
         launch[c] = load && (int'(sel) == c);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend  <= '0;
         valid <= 1'b0;
         addr  <= '0;
         data  <= '0;
      end else begin
         pend <= ((pend & ~launch) | msg_fire) & act;
         if (!valid || ready) valid <= hit;
         if (load) begin
            addr <= words[int'(sel)*WORD_W + MSG_W +: MSG_W];
            data <= words[int'(sel)*WORD_W +: MSG_W];
         end
      end
   end
endmodule

// File: rtl/irq_route_hub.sv
module irq_route_hub #(
   parameter int N_CH     = 8,
   parameter int N_LINES  = 24,
   parameter int ROUTE_W  = 5,
   parameter int INV_FROM = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_CH-1:0]         fire_i,
   input  logic                    glob_en_i,
   input  logic                    legacy_i,
   input  logic [N_CH-1:0]         ch_en_i,
   input  logic [N_CH-1:0]         ch_level_i,
   input  logic [N_CH-1:0]         ch_msg_en_i,
   input  logic [N_CH*ROUTE_W-1:0] ch_route_i,
   input  logic [N_CH*64-1:0]      ch_msg_word_i,
   input  logic                    sts_wr_i,
   input  logic [N_CH-1:0]         sts_wdata_i,
   input  logic                    pit_irq_i,
   input  logic                    rtc_irq_i,
   output logic [N_LINES-1:0]      irq_o,
   output logic [N_CH-1:0]         sts_o,
   output logic                    pit_en_o,
   output logic                    msg_valid_o,
   input  logic                    msg_ready_i,
   output logic [31:0]             msg_addr_o,
   output logic [31:0]             msg_data_o
);
   import irq_route_pkg::*;

   initial begin : param_check
      assert (N_CH >= 2 && N_CH <= 32) else $error("N_CH out of range");
      assert (N_LINES > LEG_LINE_B) else $error("N_LINES too small");
      assert ((1 << ROUTE_W) >= N_LINES) else $error("ROUTE_W too narrow");
   end

   logic [N_CH-1:0] act;
   logic [N_CH-1:0] pulse;
   logic [N_CH-1:0] msg_fire;
   logic            rtc_q;

   assign act = ch_en_i & {N_CH{glob_en_i}};

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      irq_chan_state u_st (
         .clk      (clk),
         .rst_n    (rst_n),
         .fire     (fire_i[c]),
         .act      (act[c]),
         .level    (ch_level_i[c]),
         .msg_en   (ch_msg_en_i[c]),
         .clr_req  (sts_wr_i & sts_wdata_i[c]),
         .sts      (sts_o[c]),
         .pulse    (pulse[c]),
         .msg_fire (msg_fire[c])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rtc_q    <= 1'b0;
         pit_en_o <= 1'b1;
      end else begin
         rtc_q    <= rtc_irq_i;
         pit_en_o <= ~legacy_i;
      end
   end

   irq_line_map #(
      .N_CH(N_CH), .N_LINES(N_LINES), .ROUTE_W(ROUTE_W), .INV_FROM(INV_FROM)
   ) u_map (
      .sts     (sts_o),
      .pulse   (pulse),
      .route   (ch_route_i),
      .legacy  (legacy_i),
      .pit_in  (pit_irq_i),
      .rtc_lvl (rtc_q),
      .irq     (irq_o)
   );

   irq_msg_arb #(.N_CH(N_CH)) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .act      (act),
      .msg_fire (msg_fire),
      .words    (ch_msg_word_i),
      .ready    (msg_ready_i),
      .valid    (msg_valid_o),
      .addr     (msg_addr_o),
      .data     (msg_data_o)
   );
endmodule

// File: rtl/irq_route_hub_chk.sv
module irq_route_hub_chk #(
   parameter int N_CH     = 8,
   parameter int N_LINES  = 24,
   parameter int ROUTE_W  = 5,
   parameter int INV_FROM = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [N_CH-1:0]         fire_i,
   input logic                    glob_en_i,
   input logic                    legacy_i,
   input logic [N_CH-1:0]         ch_en_i,
   input logic [N_CH-1:0]         ch_level_i,
   input logic [N_CH-1:0]         ch_msg_en_i,
   input logic                    sts_wr_i,
   input logic [N_CH-1:0]         sts_wdata_i,
   input logic [N_CH-1:0]         sts_o,
   input logic                    pit_en_o,
   input logic                    msg_valid_o,
   input logic                    msg_ready_i,
   input logic [31:0]             msg_addr_o,
   input logic [31:0]             msg_data_o
);
   for (genvar c = 0; c < N_CH; c++) begin : g_c
      wire a = ch_en_i[c] & glob_en_i;

      p_level_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (a && fire_i[c] && ch_level_i[c] && !ch_msg_en_i[c]) |=> sts_o[c]);

      p_edge_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (a && fire_i[c] && !ch_level_i[c] && !ch_msg_en_i[c]) |=> !sts_o[c]);

      p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (sts_wr_i && sts_wdata_i[c] && !fire_i[c]) |=> !sts_o[c]);

      p_disable_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !a |=> !sts_o[c]);

      p_msg_no_sts_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (fire_i[c] && ch_msg_en_i[c] && !sts_o[c]) |=> !sts_o[c]);
   end

   p_msg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid_o && !msg_ready_i) |=>
         (msg_valid_o && $stable(msg_addr_o) && $stable(msg_data_o)));

   p_pit_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      legacy_i |=> !pit_en_o);

   p_pit_on_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !legacy_i |=> pit_en_o);
endmodule

bind irq_route_hub irq_route_hub_chk #(
   .N_CH(N_CH), .N_LINES(N_LINES), .ROUTE_W(ROUTE_W), .INV_FROM(INV_FROM)
) u_chk (.*);

// File: tb/irq_route_hub_tb_top.sv
module irq_route_hub_tb_top;
   localparam int N_CH = 8, N_LINES = 24, ROUTE_W = 5, INV_FROM = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [N_CH-1:0] fire = '0, ch_en = '1, level = '0, msg_en = '0, wdata = '0;
   logic glob_en = 1'b1, legacy = 1'b0, sts_wr = 1'b0, pit_in = 1'b0, rtc_in = 1'b0;
   logic ready = 1'b0;
   logic [N_CH-1:0][ROUTE_W-1:0] route_v;
   logic [N_CH-1:0][63:0] word_v;
   logic [N_LINES-1:0] irq_o;
   logic [N_CH-1:0] sts_o;
   logic pit_en_o, msg_valid_o;
   logic [31:0] msg_addr_o, msg_data_o;

   int checks = 0, bad = 0;

   // model state
   logic [N_CH-1:0] m_sts, m_pulse, m_msgq, m_pend;
   logic m_mv, m_rtc, m_pit;
   logic [31:0] m_addr, m_data;

   always #5 clk = ~clk;

   irq_route_hub #(.N_CH(N_CH), .N_LINES(N_LINES), .ROUTE_W(ROUTE_W), .INV_FROM(INV_FROM))
   dut_i (
      .clk(clk), .rst_n(rst_n), .fire_i(fire), .glob_en_i(glob_en), .legacy_i(legacy),
      .ch_en_i(ch_en), .ch_level_i(level), .ch_msg_en_i(msg_en), .ch_route_i(route_v),
      .ch_msg_word_i(word_v), .sts_wr_i(sts_wr), .sts_wdata_i(wdata), .pit_irq_i(pit_in),
      .rtc_irq_i(rtc_in), .irq_o(irq_o), .sts_o(sts_o), .pit_en_o(pit_en_o),
      .msg_valid_o(msg_valid_o), .msg_ready_i(ready), .msg_addr_o(msg_addr_o),
      .msg_data_o(msg_data_o)
   );

   function automatic logic [N_LINES-1:0] exp_irq();
      logic [N_LINES-1:0] a = '0;
      for (int c = 0; c < N_CH; c++) begin
         int r = int'(route_v[c]);
         if (legacy && c == 0) r = 0;
         if (legacy && c == 1) r = 8;
         if (r < N_LINES) a[r] = a[r] | m_sts[c] | m_pulse[c];
      end
      if (!legacy) begin
         a[0] = a[0] | pit_in;
         a[8] = a[8] | m_rtc;
      end
      for (int l = INV_FROM; l < N_LINES; l++) a[l] = ~a[l];
      return a;
   endfunction

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic model_reset();
      m_sts = '0; m_pulse = '0; m_msgq = '0; m_pend = '0;
      m_mv = 1'b0; m_rtc = 1'b0; m_pit = 1'b1; m_addr = '0; m_data = '0;
   endtask

   task automatic model_step();
      logic [N_CH-1:0] n_sts, n_pulse, mf, launch;
      logic hit; int sel;
      hit = 1'b0; sel = 0; launch = '0;
      for (int c = 0; c < N_CH; c++) begin
         logic a = ch_en[c] & glob_en;
         n_pulse[c] = a & fire[c] & ~msg_en[c] & ~level[c];
         mf[c] = a & fire[c] & msg_en[c];
         if (!a) n_sts[c] = 1'b0;
         else if (msg_en[c] & ~m_msgq[c]) n_sts[c] = 1'b0;
         else if (fire[c] & ~msg_en[c]) n_sts[c] = level[c];
         else if (sts_wr & wdata[c]) n_sts[c] = 1'b0;
         else n_sts[c] = m_sts[c];
      end
      for (int c = N_CH - 1; c >= 0; c--)
         if (m_pend[c]) begin hit = 1'b1; sel = c; end
      if (!m_mv || ready) begin
         m_mv = hit;
         if (hit) begin
            launch[sel] = 1'b1;
            m_addr = word_v[sel][63:32];
            m_data = word_v[sel][31:0];
         end
      end
      m_pend = ((m_pend & ~launch) | mf) & ch_en & {N_CH{glob_en}};
      m_sts = n_sts; m_pulse = n_pulse; m_msgq = msg_en;
      m_rtc = rtc_in; m_pit = ~legacy;
   endtask

   task automatic compare(input string tag);
      chk({tag, " irq_o"}, 64'(irq_o), 64'(exp_irq()));
      chk({tag, " sts_o"}, 64'(sts_o), 64'(m_sts));
      chk({tag, " pit_en_o"}, 64'(pit_en_o), 64'(m_pit));
      chk({tag, " msg_valid_o"}, 64'(msg_valid_o), 64'(m_mv));
      if (m_mv) chk({tag, " msg addr/data"}, {msg_addr_o, msg_data_o}, {m_addr, m_data});
   endtask

   task automatic tick(input string tag);
      @(posedge clk);
      model_step();
      #1;
      compare(tag);
      @(negedge clk);
   endtask

   task automatic fire1(input int c, input string tag);
      fire[c] = 1'b1;
      tick(tag);
      fire = '0;
   endtask

   task automatic clear_all(input string tag);
      sts_wr = 1'b1; wdata = '1;
      tick(tag);
      sts_wr = 1'b0; wdata = '0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'h5eed_1234));
      for (int c = 0; c < N_CH; c++) begin
         route_v[c] = ROUTE_W'(c + 2);
         word_v[c]  = {32'hA000_0000 + 32'(c), 32'hD000_0000 + 32'(c)};
      end
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 sts_o", 64'(sts_o), 64'h0);
      chk("R1 pit_en_o", 64'(pit_en_o), 64'h1);
      chk("R1 msg_valid_o", 64'(msg_valid_o), 64'h0);
      chk("R1 irq_o", 64'(irq_o), 64'hFF_0000);
      @(negedge clk);

      // R2 level fire, channel 3 on line 5
      level[3] = 1'b1;
      fire1(3, "R2");
      chk("R2 sts bit", 64'(sts_o[3]), 64'h1);
      chk("R2 line 5", 64'(irq_o[5]), 64'h1);
      tick("R2 hold");
      chk("R2 line 5 held", 64'(irq_o[5]), 64'h1);

      // R4 zero write then one write
      sts_wr = 1'b1; wdata = '0;
      tick("R4 zero write");
      chk("R4 zero write keeps bit", 64'(sts_o[3]), 64'h1);
      wdata = 8'h08;
      tick("R4 one write");
      sts_wr = 1'b0; wdata = '0;
      chk("R4 bit cleared", 64'(sts_o[3]), 64'h0);
      chk("R4 line 5 low", 64'(irq_o[5]), 64'h0);

      // R3 pulse mode, channel 4 on line 6
      fire1(4, "R3");
      chk("R3 line 6 pulse", 64'(irq_o[6]), 64'h1);
      chk("R3 sts bit", 64'(sts_o[4]), 64'h0);
      tick("R3 after");
      chk("R3 pulse one cycle", 64'(irq_o[6]), 64'h0);

      // R5 active-low line 18
      level[2] = 1'b1; route_v[2] = 5'd18;
      fire1(2, "R5");
      chk("R5 line 18 low", 64'(irq_o[18]), 64'h0);
      clear_all("R5 clear");
      chk("R5 line 18 idle high", 64'(irq_o[18]), 64'h1);

      // R6 channel and global disable
      fire1(3, "R6 set");
      ch_en[3] = 1'b0;
      tick("R6 ch disable");
      chk("R6 sts cleared", 64'(sts_o[3]), 64'h0);
      fire1(3, "R6 fire ignored");
      chk("R6 fire ignored", 64'(sts_o[3]), 64'h0);
      ch_en[3] = 1'b1;
      fire1(2, "R6 set 2");
      glob_en = 1'b0;
      tick("R6 glob disable");
      chk("R6 glob clears", 64'(sts_o[2]), 64'h0);
      glob_en = 1'b1;

      // R8 message-mode rise clears pending status
      level[5] = 1'b1;
      fire1(5, "R8 set");
      chk("R8 pre sts", 64'(sts_o[5]), 64'h1);
      msg_en[5] = 1'b1;
      tick("R8 rise");
      chk("R8 sts cleared", 64'(sts_o[5]), 64'h0);

      // R7 message write with backpressure
      fire1(5, "R7 fire");
      chk("R7 no line", 64'(irq_o[7]), 64'h0);
      chk("R7 no sts", 64'(sts_o[5]), 64'h0);
      tick("R7 launch");
      chk("R7 valid", 64'(msg_valid_o), 64'h1);
      chk("R7 addr/data", {msg_addr_o, msg_data_o}, {32'hA000_0005, 32'hD000_0005});
      repeat (3) tick("R7 hold");
      chk("R7 still valid", 64'(msg_valid_o), 64'h1);
      ready = 1'b1;
      tick("R7 accept");
      chk("R7 done", 64'(msg_valid_o), 64'h0);
      ready = 1'b0;

      // R13 ordering
      msg_en[6] = 1'b1; msg_en[1] = 1'b1;
      tick("R13 mode");
      fire[6] = 1'b1; fire[1] = 1'b1;
      tick("R13 fire");
      fire = '0;
      fire1(6, "R13 coalesce");
      chk("R13 first ch1", 64'(msg_addr_o), 64'hA000_0001);
      ready = 1'b1;
      tick("R13 second");
      chk("R13 then ch6", 64'(msg_addr_o), 64'hA000_0006);
      tick("R13 drained");
      chk("R13 single ch6 write", 64'(msg_valid_o), 64'h0);
      ready = 1'b0;
      msg_en = '0;

      // R9 legacy override
      legacy = 1'b1; level[0] = 1'b1; level[1] = 1'b1;
      route_v[0] = 5'd10; route_v[1] = 5'd11;
      tick("R9 enter");
      fire1(0, "R9 ch0");
      chk("R9 line 0", 64'(irq_o[0]), 64'h1);
      chk("R9 not line 10", 64'(irq_o[10]), 64'h0);
      fire1(1, "R9 ch1");
      chk("R9 line 8", 64'(irq_o[8]), 64'h1);
      clear_all("R9 clear");

      // R10 legacy blocks inputs
      pit_in = 1'b1; rtc_in = 1'b1;
      tick("R10 blocked");
      chk("R10 line 0", 64'(irq_o[0]), 64'h0);
      chk("R10 line 8", 64'(irq_o[8]), 64'h0);
      chk("R10 pit_en", 64'(pit_en_o), 64'h0);

      // R11 leave legacy, recorded RTC level shows
      rtc_in = 1'b0; tick("R11 rtc low");
      rtc_in = 1'b1; tick("R11 rtc high");
      legacy = 1'b0;
      #1;
      chk("R11 line 8 restored", 64'(irq_o[8]), 64'h1);
      chk("R12 pit on line 0", 64'(irq_o[0]), 64'h1);
      tick("R11 exit");
      chk("R11 pit_en", 64'(pit_en_o), 64'h1);

      // R12 pass-through
      rtc_in = 1'b0; pit_in = 1'b0;
      tick("R12 drop");
      chk("R12 line 8 follows", 64'(irq_o[8]), 64'h0);
      chk("R12 line 0 follows", 64'(irq_o[0]), 64'h0);

      // random phase
      for (int i = 0; i < 4000; i++) begin
         fire   = N_CH'($urandom & $urandom);
         sts_wr = ($urandom_range(3) == 0);
         wdata  = N_CH'($urandom);
         ready  = ($urandom_range(2) != 0);
         pit_in = $urandom_range(1);
         rtc_in = $urandom_range(1);
         if ($urandom_range(15) == 0) legacy = ~legacy;
         if ($urandom_range(31) == 0) glob_en = ~glob_en;
         if ($urandom_range(7) == 0) begin
            int c = $urandom_range(N_CH - 1);
            ch_en[c]  = ($urandom_range(5) != 0);
            level[c]  = $urandom_range(1);
            msg_en[c] = ($urandom_range(2) == 0);
            route_v[c] = ROUTE_W'($urandom_range(N_LINES - 1));
            word_v[c]  = {$urandom, $urandom};
         end
         tick("R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12 R13 random");
      end

      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule